// File: doc/BRIEF.md
# Path Status Byte Receiver

This block sits on the receive side of a path overhead processor. Once per frame it takes the received path status byte and splits it into two fields. The first field is the far-end block error count. Each valid nibble of that count is added to a 16-bit running total. A one-second pulse copies the total to an output register and starts a new interval.

The second field is the three-bit remote defect code. A new code is accepted only after the same value has arrived in a number of consecutive frames. The accepted code is then decoded into one of five defect classes, and a summary path defect flag is raised for the classes that call for it. Upstream alarm inputs stop error counting while any alarm is active.

Status bytes come in on a valid/ready stream. The block never applies back-pressure: `sb_ready` is high whenever reset is released, and each cycle with `sb_valid` high counts as one frame. When `sb_valid` is low the byte lines are ignored.

Top module: `sb_path_status_rx`

## Requirements
- R1: After reset, `err_count` is 0, `rdi_code` is 000, `def_none` is 1 and every other defect flag is 0.
- R2: Bits 1–4 of the status byte, held on `sb_byte[7:4]` (bit 1 is the MSB, bit 7 of the port), form the error nibble. When the nibble is 0 to 8, each accepted frame adds it to the running total.
- R3: An error nibble of 9 to 15 adds zero.
- R4: While any bit of `alarm_in` is high, a frame adds nothing to the running total.
- R5: In the cycle that `sec_tick` is high, `err_count` takes the running total as it stood before that cycle's frame, and it is visible on the next cycle. The running total restarts at that cycle's frame contribution, or at 0 when there is no frame. Without `sec_tick`, `err_count` holds its value.
- R6: The running total saturates at FFFFh and does not wrap.
- R7: Bits 5–7 of the status byte, held on `sb_byte[3:1]`, are taken into `rdi_code` only after 10 consecutive frames carry the same value. The new value is visible in the cycle after the 10th frame.
- R8: A frame that carries a different code restarts the run, so a run of 9 frames is never accepted.
- R9: Exactly one class flag is high, decoded from `rdi_code`: 000, 001 and 011 give `def_none`; 100 and 111 give `def_one_bit`; 010 gives `def_payload`; 101 gives `def_server`; 110 gives `def_connect`.
- R10: `path_rdi` is high exactly when `def_one_bit`, `def_server` or `def_connect` is high.
- R11: `sb_ready` is 1 after reset. Cycles with `sb_valid` low change neither the running total nor the defect run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sb_valid | input | 1 | Status byte valid, one frame per beat |
| sb_ready | output | 1 | Always high out of reset |
| sb_byte | input | 8 | Received path status byte |
| sec_tick | input | 1 | One-second latch pulse |
| alarm_in | input | 6 | Upstream alarms: loss of signal, loss of frame, line AIS, path AIS, loss of pointer, unequipped |
| err_count | output | 16 | Latched error total of the last interval |
| rdi_code | output | 3 | Accepted remote defect code |
| def_none | output | 1 | No defect class |
| def_one_bit | output | 1 | One-bit defect class |
| def_payload | output | 1 | Payload defect class |
| def_server | output | 1 | Server defect class |
| def_connect | output | 1 | Connectivity defect class |
| path_rdi | output | 1 | Summary path defect indication |

## Verification
Every result arrives one clock after the edge that takes in its cause. The running total grows on the edge of a frame. `err_count` changes on the edge of a tick. `rdi_code` and the class flags change on the edge of the 10th matching frame, because the decoder is combinational. The bench drives each beat on a falling edge and reads the outputs on the next falling edge, which falls after exactly one register stage. For persistence, it reads after the 9th frame to confirm nothing has changed yet, and again after the 10th to see the new code.

// File: rtl/sb_path_status_pkg.sv
package sb_path_status_pkg;

  typedef struct packed {
    logic none;
    logic one_bit;
    logic payload;
    logic server;
    logic connect;
  } rdi_class_t;

  function automatic rdi_class_t decode_rdi(input logic [2:0] code);
    rdi_class_t c;
    c = '0;
    unique case (code)
      3'b100, 3'b111: c.one_bit = 1'b1;
      3'b010:         c.payload = 1'b1;
      3'b101:         c.server  = 1'b1;
      3'b110:         c.connect = 1'b1;
      default:        c.none    = 1'b1;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sb_err_counter.sv
module sb_err_counter #(
  parameter int CNT_W   = 16,
  parameter int NIB_W   = 4,
  parameter int NIB_MAX = 8,
  parameter int N_ALARM = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame,
  input  logic [NIB_W-1:0]   nibble,
  input  logic [N_ALARM-1:0] alarm,
  input  logic               tick,
  output logic [CNT_W-1:0]   total,
  output logic [CNT_W-1:0]   latched
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] contrib;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] latched_q;

  always_comb begin
    contrib = '0;
    if (frame && (alarm == '0) && (int'(nibble) <= NIB_MAX))
      contrib = CNT_W'(nibble);
    sum = {1'b0, total_q} + {1'b0, contrib};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q   <= '0;
      latched_q <= '0;
    end else if (tick) begin
      latched_q <= total_q;
      total_q   <= contrib;
    end else if (sum[CNT_W]) begin
      total_q <= SAT;
    end else begin
      total_q <= sum[CNT_W-1:0];
    end
  end

  assign total   = total_q;
  assign latched = latched_q;
endmodule

// File: rtl/sb_persist.sv
module sb_persist #(
  parameter int W     = 3,
  parameter int DEPTH = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame,
  input  logic [W-1:0] value,
  output logic [W-1:0] accepted
);
  localparam int RUN_W = $clog2(DEPTH + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(DEPTH);

  logic [W-1:0]     cand_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_nx;
  logic [W-1:0]     acc_q;

  always_comb begin
    if (value != cand_q)       run_nx = RUN_W'(1);
    else if (run_q == RUN_MAX) run_nx = RUN_MAX;
    else                       run_nx = run_q + RUN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
      run_q  <= '0;
      acc_q  <= '0;
    end else if (frame) begin
      cand_q <= value;
      run_q  <= run_nx;
      if (run_nx == RUN_MAX) acc_q <= value;
    end
  end

  assign accepted = acc_q;
endmodule

// File: rtl/sb_rdi_decode.sv
module sb_rdi_decode
  import sb_path_status_pkg::*;
(
  input  logic [2:0] code,
  output rdi_class_t cls,
  output logic       path_def
);
  always_comb begin
    cls      = decode_rdi(code);
    path_def = cls.one_bit | cls.server | cls.connect;
  end
endmodule

// File: rtl/sb_path_status_rx.sv
module sb_path_status_rx
  import sb_path_status_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PERSIST = 10,
  parameter int NIB_MAX = 8,
  parameter int N_ALARM = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sb_valid,
  output logic               sb_ready,
  input  logic [7:0]         sb_byte,
  input  logic               sec_tick,
  input  logic [N_ALARM-1:0] alarm_in,
  output logic [CNT_W-1:0]   err_count,
  output logic [2:0]         rdi_code,
  output logic               def_none,
  output logic               def_one_bit,
  output logic               def_payload,
  output logic               def_server,
  output logic               def_connect,
  output logic               path_rdi
);
  localparam int NIB_W  = 4;
  localparam int CODE_W = 3;

  logic             ready_q;
  logic             frame;
  logic [CNT_W-1:0] run_total;
  rdi_class_t       cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign sb_ready = ready_q;
  assign frame    = sb_valid & ready_q;

  sb_err_counter #(
    .CNT_W(CNT_W), .NIB_W(NIB_W), .NIB_MAX(NIB_MAX), .N_ALARM(N_ALARM)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .frame(frame),
    .nibble(sb_byte[7:4]), .alarm(alarm_in), .tick(sec_tick),
    .total(run_total), .latched(err_count)
  );

  sb_persist #(.W(CODE_W), .DEPTH(PERSIST)) u_pers (
    .clk(clk), .rst_n(rst_n), .frame(frame),
    .value(sb_byte[3:1]), .accepted(rdi_code)
  );

  sb_rdi_decode u_dec (.code(rdi_code), .cls(cls), .path_def(path_rdi));

  assign def_none    = cls.none;
  assign def_one_bit = cls.one_bit;
  assign def_payload = cls.payload;
  assign def_server  = cls.server;
  assign def_connect = cls.connect;
endmodule

// File: rtl/sb_path_status_chk.sv
module sb_path_status_chk #(
  parameter int CNT_W   = 16,
  parameter int N_ALARM = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sb_valid,
  input logic               sb_ready,
  input logic               sec_tick,
  input logic [N_ALARM-1:0] alarm_in,
  input logic [CNT_W-1:0]   err_count,
  input logic [CNT_W-1:0]   run_total,
  input logic [2:0]         rdi_code,
  input logic               def_none,
  input logic               def_one_bit,
  input logic               def_payload,
  input logic               def_server,
  input logic               def_connect,
  input logic               path_rdi
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};
  logic frame;
  assign frame = sb_valid & sb_ready;

  AST_TICK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> err_count == $past(run_total)); // R5
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable(err_count)); // R5
  AST_ALARM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && (alarm_in != '0) && !sec_tick) |=> $stable(run_total)); // R4
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && run_total == SAT) |=> run_total == SAT); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame && !sec_tick) |=> $stable(run_total)); // R11
  AST_RDI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame |=> $stable(rdi_code)); // R7
  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({def_none, def_one_bit, def_payload, def_server, def_connect}) == 1); // R9
  AST_PDI_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    path_rdi == (def_one_bit | def_server | def_connect)); // R10
endmodule

bind sb_path_status_rx sb_path_status_chk #(.CNT_W(CNT_W), .N_ALARM(N_ALARM)) u_chk (
  .clk(clk), .rst_n(rst_n), .sb_valid(sb_valid), .sb_ready(sb_ready),
  .sec_tick(sec_tick), .alarm_in(alarm_in), .err_count(err_count),
  .run_total(run_total), .rdi_code(rdi_code), .def_none(def_none),
  .def_one_bit(def_one_bit), .def_payload(def_payload),
  .def_server(def_server), .def_connect(def_connect), .path_rdi(path_rdi)
);

// File: tb/test_sb_path_status_rx.sv
module test_sb_path_status_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sb_valid = 1'b0;
  logic        sb_ready;
  logic [7:0]  sb_byte = '0;
  logic        sec_tick = 1'b0;
  logic [5:0]  alarm_in = '0;
  logic [15:0] err_count;
  logic [2:0]  rdi_code;
  logic        def_none, def_one_bit, def_payload, def_server, def_connect, path_rdi;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sb_path_status_rx i_sb_path_status_rx (
    .clk(clk), .rst_n(rst_n), .sb_valid(sb_valid), .sb_ready(sb_ready),
    .sb_byte(sb_byte), .sec_tick(sec_tick), .alarm_in(alarm_in),
    .err_count(err_count), .rdi_code(rdi_code), .def_none(def_none),
    .def_one_bit(def_one_bit), .def_payload(def_payload),
    .def_server(def_server), .def_connect(def_connect), .path_rdi(path_rdi)
  );

  // {nibble, code, flags {none,one_bit,payload,server,connect,path_rdi}}
  localparam logic [12:0] VEC [8] = '{
    {4'd1, 3'b000, 6'b100000},
    {4'd2, 3'b001, 6'b100000},
    {4'd3, 3'b011, 6'b100000},
    {4'd4, 3'b100, 6'b010001},
    {4'd5, 3'b111, 6'b010001},
    {4'd6, 3'b010, 6'b001000},
    {4'd7, 3'b101, 6'b000101},
    {4'd8, 3'b110, 6'b000011}
  };

  function automatic logic [5:0] flags();
    return {def_none, def_one_bit, def_payload, def_server, def_connect, path_rdi};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] nib, input logic [2:0] code, input logic tk = 1'b0);
    @(negedge clk);
    sb_valid = 1'b1;
    sb_byte  = {nib, code, 1'b0};
    sec_tick = tk;
    @(negedge clk);
    sb_valid = 1'b0;
    sec_tick = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count", err_count, 0);
    check("R1 code", rdi_code, 0);
    check("R1 flags", flags(), 6'b100000);
    check("R11 ready", sb_ready, 1);

    // Table walk: each code held for 10 frames, nibbles accumulate.
    for (int k = 0; k < 8; k++) begin
      for (int f = 0; f < 10; f++) send(VEC[k][12:9], VEC[k][8:6]);
      check("R7 code", rdi_code, VEC[k][8:6]);
      check("R9 R10 flags", flags(), VEC[k][5:0]);
    end
    tick();
    check("R2 sum 360", err_count, 360);

    // R3: nibbles 9..15 add zero
    send(4'd9, 3'b110);
    send(4'd15, 3'b110);
    tick();
    check("R3 large nibble", err_count, 0);

    // R4: each alarm blocks counting
    for (int a = 0; a < 6; a++) begin
      alarm_in = 6'(1 << a);
      send(4'd5, 3'b110);
    end
    alarm_in = '0;
    send(4'd2, 3'b110);
    tick();
    check("R4 alarm gate", err_count, 2);

    // R5: tick with frame in same cycle
    send(4'd3, 3'b110);
    send(4'd4, 3'b110, 1'b1);
    check("R5 latch before frame", err_count, 3);
    @(negedge clk);
    check("R5 hold", err_count, 3);
    tick();
    check("R5 restart", err_count, 4);

    // R8: interrupted run, R7 boundary
    for (int f = 0; f < 9; f++) send(4'd0, 3'b101);
    check("R7 nine frames", rdi_code, 3'b110);
    send(4'd0, 3'b110);
    for (int f = 0; f < 9; f++) send(4'd0, 3'b101);
    check("R8 interrupted", rdi_code, 3'b110);
    send(4'd0, 3'b101);
    check("R7 tenth frame", rdi_code, 3'b101);
    check("R9 server", flags(), 6'b000101);
    tick();

    // R11: valid low ignored
    @(negedge clk);
    sb_byte = 8'h84;
    repeat (12) @(negedge clk);
    check("R11 code", rdi_code, 3'b101);
    tick();
    check("R11 count", err_count, 0);

    // R6: saturation
    for (int f = 0; f < 8200; f++) send(4'd8, 3'b101);
    tick();
    check("R6 saturate", err_count, 16'hFFFF);
    tick();
    check("R5 empty interval", err_count, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule